// File: doc/BRIEF.md
# Event Counter Timer with Sticky Overflow Flag

This block is one timer/counter channel with a byte-wide register port. Each enabled cycle it advances by one. The advance comes either from the system clock or from qualified falling edges on an external event pin. A rollover sets a sticky overflow flag. Software can poll that flag through the control register, or see it on the `irq` output when `irq_en` is high.

There are two count layouts:
- **Wide mode:** the two count bytes form a single 16-bit counter that wraps from 0xFFFF to 0x0000.
- **Reload mode:** only the low byte counts. On rollover the low byte is reloaded from the high byte.

The event pin goes through a two-flop synchronizer and then a glitch-filter state machine. The filter has four states:
- `EDG_HIGH` moves to `EDG_FALL_PEND` on a low sample.
- `EDG_FALL_PEND` returns to `EDG_HIGH` on a high sample (glitch rejected). On a second low sample it moves to `EDG_LOW` and issues one count tick (transition FALL_CONFIRM).
- `EDG_LOW` moves to `EDG_RISE_PEND` on a high sample.
- `EDG_RISE_PEND` falls back to `EDG_LOW` on a low sample, or confirms `EDG_HIGH` on a second high sample.

Two further state machines hold the control bits:
- **Run:** `RUN_HALT` and `RUN_ACTIVE`. Transitions START and STOP come from control writes.
- **Flag:** `FLG_CLR` and `FLG_SET`. Transition OVERFLOW comes from hardware. Transitions SW_CLEAR and SW_SET come from a control write.

A hardware overflow outranks a software clear landing in the same cycle.

Register map (`addr`):
- **0, setup:** bit 2 selects the pin as source (1) or the clock (0). Bits 1:0 are the count mode: 2 selects reload mode, any other value selects wide mode.
- **1, control:** bit 0 is run, bit 1 is the overflow flag.
- **2:** low count byte.
- **3:** high count byte.

A write happens on a rising clock edge while `wr_en` is high. `rdata` shows the register at `addr` combinationally. Unused read bits are zero.

Top module: `evtmr`

## Requirements
- R1: After reset the setup register, the control register (run = 0, flag = 0), both count bytes and `irq` all read zero.
- R2: With run = 1 and setup bit 2 = 0, the count advances by exactly one on every rising clock edge. The edge on which a control write clears run still advances it.
- R3: In wide mode (setup bits 1:0 not equal to 2), the high:low pair steps from 0xFFFF to 0x0000 and the flag (control bit 1) becomes 1 on that edge.
- R4: In reload mode (setup bits 1:0 = 2), only the low byte counts. An advance from 0xFF loads the high byte into the low byte, leaves the high byte unchanged, and sets the flag.
- R5: With setup bit 2 = 1, every falling transition of `ev_pin` that stays low for at least two sampling edges (after the pin was stably high) adds exactly one. The increment lands on the fourth rising edge after the pin goes low.
- R6: A low pulse on `ev_pin` seen by only one sampling edge never advances the count. A one-edge high blip while the pin is low does not create a second event.
- R7: The flag stays at 1 until a control write with bit 1 = 0. It can be read without `irq_en`.
- R8: When a control write clearing the flag (even with run cleared in the same write) lands on the edge of a hardware overflow, the flag ends at 1.
- R9: With run = 0 the count bytes and the flag hold their values.
- R10: A count-byte write takes effect on the next edge. If it coincides with an advance, the written value is kept and that advance is discarded.
- R11: Rewriting the setup register while run = 0 changes neither the count nor the flag.
- R12: `irq` is 1 exactly when the flag is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ev_pin | input | 1 | Asynchronous external event input |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Level interrupt request |

## Verification
Several properties are checked on every cycle by the embedded assertions:
- the hardware-set priority on the flag;
- flag stickiness;
- the wrap-to-zero and reload outcomes;
- count-write precedence;
- freezing while stopped;
- the rule that a pin tick only follows two low samples.

Only the directed scenarios can show the exact four-edge pin latency and the glitch rejection seen at the count. They also cover the combined stop-and-clear write racing an overflow, and the absence of side effects from setup rewrites while halted.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    localparam int REG_ADDR_W = 2;
    localparam int SETUP_W    = 3;

    localparam logic [REG_ADDR_W-1:0] A_SETUP = 2'd0;
    localparam logic [REG_ADDR_W-1:0] A_CTRL  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] A_LOW   = 2'd2;
    localparam logic [REG_ADDR_W-1:0] A_HIGH  = 2'd3;

    localparam logic [1:0] LAYOUT_RELOAD8 = 2'd2;

    localparam int BIT_SRC_PIN = 2;
    localparam int BIT_RUN     = 0;
    localparam int BIT_FLAG    = 1;

    typedef enum logic [1:0] {
        EDG_HIGH      = 2'd0,
        EDG_FALL_PEND = 2'd1,
        EDG_LOW       = 2'd2,
        EDG_RISE_PEND = 2'd3
    } edge_state_e;

    typedef enum logic {
        RUN_HALT   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    typedef enum logic {
        FLG_CLR = 1'b0,
        FLG_SET = 1'b1
    } flag_state_e;

endpackage

// File: rtl/evtmr_edge_filter.sv
module evtmr_edge_filter
    import evtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic ev_tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    edge_state_e            state_q, state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign lvl = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDG_HIGH;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDG_HIGH:      state_d = lvl ? EDG_HIGH : EDG_FALL_PEND;
            EDG_FALL_PEND: state_d = lvl ? EDG_HIGH : EDG_LOW;
            EDG_LOW:       state_d = lvl ? EDG_RISE_PEND : EDG_LOW;
            EDG_RISE_PEND: state_d = lvl ? EDG_HIGH : EDG_LOW;
        endcase
    end

    // outputs: FALL_CONFIRM transition issues the tick
    always_comb begin
        ev_tick = 1'b0;
        unique case (state_q)
            EDG_FALL_PEND: ev_tick = !lvl;
            EDG_HIGH, EDG_LOW, EDG_RISE_PEND: ev_tick = 1'b0;
        endcase
    end

    AST_TICK_TWO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tick |-> (!lvl && !$past(lvl))); // R6

endmodule

// File: rtl/evtmr_count_core.sv
module evtmr_count_core
    import evtmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic [1:0]        layout,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              ovf_evt
);

    localparam int WIDE_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_d, hi_d;
    logic [WIDE_W-1:0] wide_inc;
    logic              reload_mode;

    assign reload_mode = (layout == LAYOUT_RELOAD8);
    assign wide_inc    = {hi_q, lo_q} + {{(WIDE_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    always_comb begin
        lo_d    = lo_q;
        hi_d    = hi_q;
        ovf_evt = 1'b0;
        if (lo_wr || hi_wr) begin
            if (lo_wr) lo_d = wdata;
            if (hi_wr) hi_d = wdata;
        end else if (inc) begin
            if (reload_mode) begin
                if (&lo_q) begin
                    lo_d    = hi_q;
                    ovf_evt = 1'b1;
                end else begin
                    lo_d = lo_q + {{(BYTE_W-1){1'b0}}, 1'b1};
                end
            end else begin
                {hi_d, lo_d} = wide_inc;
                ovf_evt      = &{hi_q, lo_q};
            end
        end
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !reload_mode) |=> ({hi_q, lo_q} == '0)); // R3
    AST_RELOAD_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && reload_mode) |=> (lo_q == $past(hi_q) && $stable(hi_q))); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (lo_q == $past(wdata))); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !lo_wr && !hi_wr) |=> ($stable(lo_q) && $stable(hi_q))); // R9

endmodule

// File: rtl/evtmr_ctrl.sv
module evtmr_ctrl
    import evtmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_run,
    input  logic wr_flag,
    input  logic ovf_evt,
    output logic run,
    output logic flag
);

    run_state_e  run_q, run_d;
    flag_state_e flg_q, flg_d;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= RUN_HALT;
            flg_q <= FLG_CLR;
        end else begin
            run_q <= run_d;
            flg_q <= flg_d;
        end
    end

    // run machine: START / STOP from control writes
    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_HALT:   if (ctrl_wr && wr_run)  run_d = RUN_ACTIVE;
            RUN_ACTIVE: if (ctrl_wr && !wr_run) run_d = RUN_HALT;
        endcase
    end

    // flag machine: OVERFLOW outranks SW_CLEAR / SW_SET
    always_comb begin
        flg_d = flg_q;
        unique case (flg_q)
            FLG_CLR: begin
                if (ovf_evt)                 flg_d = FLG_SET;
                else if (ctrl_wr && wr_flag) flg_d = FLG_SET;
            end
            FLG_SET: begin
                if (!ovf_evt && ctrl_wr && !wr_flag) flg_d = FLG_CLR;
            end
        endcase
    end

    // outputs
    always_comb begin
        run  = (run_q == RUN_ACTIVE);
        flag = (flg_q == FLG_SET);
    end

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flag); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ctrl_wr) |=> flag); // R7
    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_flag && !ovf_evt) |=> !flag); // R7

endmodule

// File: rtl/evtmr.sv
module evtmr
    import evtmr_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     rdata,
    input  logic                  ev_pin,
    input  logic                  irq_en,
    output logic                  irq
);

    localparam int PAD_SETUP = BYTE_W - SETUP_W;
    localparam int PAD_CTRL  = BYTE_W - 2;

    logic [SETUP_W-1:0] setup_q;
    logic               setup_wr, ctrl_wr, lo_wr, hi_wr;
    logic               ev_tick, inc, run, flag, ovf_evt;
    logic [BYTE_W-1:0]  lo_q, hi_q;

    assign setup_wr = wr_en && (addr == A_SETUP);
    assign ctrl_wr  = wr_en && (addr == A_CTRL);
    assign lo_wr    = wr_en && (addr == A_LOW);
    assign hi_wr    = wr_en && (addr == A_HIGH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        setup_q <= '0;
        else if (setup_wr) setup_q <= wdata[SETUP_W-1:0];
    end

    evtmr_edge_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
        .clk(clk), .rst_n(rst_n), .pin(ev_pin), .ev_tick(ev_tick)
    );

    assign inc = run && (setup_q[BIT_SRC_PIN] ? ev_tick : 1'b1);

    evtmr_count_core #(.BYTE_W(BYTE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .inc(inc), .layout(setup_q[1:0]),
        .lo_wr(lo_wr), .hi_wr(hi_wr), .wdata(wdata),
        .lo_q(lo_q), .hi_q(hi_q), .ovf_evt(ovf_evt)
    );

    evtmr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .wr_run(wdata[BIT_RUN]), .wr_flag(wdata[BIT_FLAG]),
        .ovf_evt(ovf_evt), .run(run), .flag(flag)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_SETUP: rdata = {{PAD_SETUP{1'b0}}, setup_q};
            A_CTRL:  rdata = {{PAD_CTRL{1'b0}}, flag, run};
            A_LOW:   rdata = lo_q;
            A_HIGH:  rdata = hi_q;
        endcase
    end

    assign irq = flag && irq_en;

    AST_HALT_FLAG_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ctrl_wr) |=> $stable(flag)); // R11
    AST_HALT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !ovf_evt); // R9

endmodule

// File: tb/sim_evtmr.sv
module sim_evtmr;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ev_pin = 1'b1;
    logic       irq_en = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    evtmr u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ev_pin(ev_pin), .irq_en(irq_en), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic expect_reg(input string req, input logic [1:0] a, input int exp);
        int v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        expect_reg("R1 setup", 2'd0, 0);
        expect_reg("R1 ctrl", 2'd1, 0);
        expect_reg("R1 low", 2'd2, 0);
        expect_reg("R1 high", 2'd3, 0);
        chk("R1 irq", int'(irq), 0);
    endtask

    task automatic t_timer_count;
        wr(2'd0, 8'h01); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
        wr(2'd1, 8'h01);
        idle(9);
        wr(2'd1, 8'h00);
        expect_reg("R2 low after 10 edges", 2'd2, 10);
        expect_reg("R2 high", 2'd3, 0);
    endtask

    task automatic t_wrap16;
        wr(2'd2, 8'hFE); wr(2'd3, 8'hFF); wr(2'd1, 8'h00);
        wr(2'd1, 8'h01);
        idle(2);
        wr(2'd1, 8'h02);
        expect_reg("R3 low after wrap", 2'd2, 8'h01);
        expect_reg("R3 high after wrap", 2'd3, 8'h00);
        expect_reg("R3 flag set", 2'd1, 8'h02);
        idle(6);
        expect_reg("R9 low frozen", 2'd2, 8'h01);
        expect_reg("R9 flag held", 2'd1, 8'h02);
        chk("R12 irq gated off", int'(irq), 0);
        expect_reg("R7 flag polled", 2'd1, 8'h02);
        irq_en = 1'b1; #1;
        chk("R12 irq raised", int'(irq), 1);
        wr(2'd1, 8'h00);
        expect_reg("R7 flag cleared", 2'd1, 0);
        chk("R12 irq dropped", int'(irq), 0);
        irq_en = 1'b0;
    endtask

    task automatic t_reload8;
        wr(2'd0, 8'h02); wr(2'd3, 8'hF0); wr(2'd2, 8'hFE);
        wr(2'd1, 8'h01);
        idle(2);
        wr(2'd1, 8'h02);
        expect_reg("R4 low reloaded", 2'd2, 8'hF1);
        expect_reg("R4 high unchanged", 2'd3, 8'hF0);
        expect_reg("R4 flag set", 2'd1, 8'h02);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_priority;
        wr(2'd0, 8'h01); wr(2'd2, 8'hFE); wr(2'd3, 8'hFF);
        wr(2'd1, 8'h01);
        idle(1);
        wr(2'd1, 8'h00);
        expect_reg("R8 flag kept, run cleared", 2'd1, 8'h02);
        expect_reg("R8 low", 2'd2, 0);
        expect_reg("R8 high", 2'd3, 0);
        wr(2'd1, 8'h00);
        expect_reg("R8 later clear", 2'd1, 0);
    endtask

    task automatic t_write_wins;
        wr(2'd2, 8'h00); wr(2'd3, 8'h00);
        wr(2'd1, 8'h01);
        idle(1);
        wr(2'd2, 8'h40);
        wr(2'd1, 8'h00);
        expect_reg("R10 write kept then one advance", 2'd2, 8'h41);
        expect_reg("R10 high", 2'd3, 0);
    endtask

    task automatic t_mode_stopped;
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF); wr(2'd1, 8'h00);
        wr(2'd0, 8'h02); wr(2'd0, 8'h05); wr(2'd0, 8'h01);
        idle(3);
        expect_reg("R11 low", 2'd2, 8'hFF);
        expect_reg("R11 high", 2'd3, 8'hFF);
        expect_reg("R11 flag", 2'd1, 0);
    endtask

    task automatic pulse(input int lo_n, input int hi_n);
        ev_pin = 1'b0; idle(lo_n);
        ev_pin = 1'b1; idle(hi_n);
    endtask

    task automatic t_ext_latency;
        wr(2'd0, 8'h05); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
        wr(2'd1, 8'h01);
        idle(3);
        ev_pin = 1'b0;
        idle(3);
        expect_reg("R5 not yet counted", 2'd2, 0);
        idle(1);
        expect_reg("R5 counted on fourth edge", 2'd2, 1);
        ev_pin = 1'b1;
        idle(4);
    endtask

    task automatic t_ext_glitch;
        pulse(1, 3); pulse(1, 3);
        idle(4);
        expect_reg("R6 narrow pulses ignored", 2'd2, 1);
        pulse(2, 3); pulse(2, 3); pulse(2, 3);
        idle(4);
        expect_reg("R5 three events", 2'd2, 4);
        ev_pin = 1'b0; idle(4);
        ev_pin = 1'b1; idle(1);
        ev_pin = 1'b0; idle(4);
        ev_pin = 1'b1; idle(4);
        expect_reg("R6 high blip no extra event", 2'd2, 5);
        wr(2'd1, 8'h00);
        expect_reg("R6 flag untouched", 2'd1, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_timer_count;
        t_wrap16;
        t_reload8;
        t_priority;
        t_write_wins;
        t_mode_stopped;
        t_ext_latency;
        t_ext_glitch;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule